// File: doc/BRIEF.md
# Condition Register Logic Unit

This block keeps a 32-bit condition register made of eight 4-bit fields and applies the register-level operations of a processor's branch and condition logic. Software-visible bit numbers run big-endian: bit index n names physical bit 31-n, and field f covers physical bits 31-4f down to 28-4f. One operation is accepted per clock when the strobe is high. Its result is committed on that rising edge, and the whole register is always visible on the read port.

The operations are:
- a two-input boolean function of two single bits, written to a third bit;
- a copy of one field into another;
- a move from a 32-bit source under an 8-bit nibble mask;
- a copy of the top four bits of the fixed-point exception register into a field;
- a write of a compare outcome (less, greater, equal, plus summary overflow) into a field.

The design has no multi-cycle sequencing. Its only state is the register itself, which has two conditions: cleared (during reset) and holding (otherwise, updated by each accepted operation).

Top module: `cr_unit`

## Requirements
- R1: A synchronous active-high reset clears the register to zero. `cr_o` always shows the full 32-bit register, unchanged.
- R2: The register holds its value when `valid_i` is low, or when `op_i` is 0 (no-op) or any code from 13 to 15.
- R3: Bit index n addresses physical bit 31-n. A bit operation changes only physical bit 31-`bt_i`, including when `bt_i` equals `ba_i` or `bb_i`.
- R4: Codes 1, 2, 3 and 4 write a&b, a|b, ~(a&b) and a^b respectively, where a is bit `ba_i` and b is bit `bb_i`.
- R5: Codes 5, 6, 7 and 8 write ~(a|b), ~(a^b), a&~b and a|~b respectively.
- R6: Code 9 copies field `bfa_i` (physical bits 31-4·bfa down to 28-4·bfa) into field `bf_i`. All other fields are unchanged, and copying a field onto itself leaves the register unchanged.
- R7: Code 10 loads nibble i (physical bits 4i+3 down to 4i) from `src_i` wherever `fxm_i[i]` is 1, and keeps the nibble wherever it is 0. A mask of zero changes nothing.
- R8: Code 11 writes `xer_hi_i[3:0]` into field `bf_i`, with `xer_hi_i[3]` landing on physical bit 31-4·bf.
- R9: Code 12 writes field `bf_i` as less, greater, equal, overflow from physical bit 31-4·bf downward. Here `cmp_i[2]` is less, `cmp_i[1]` is greater, `cmp_i[0]` is equal, and the fourth bit is `so_i`.
- R10: An accepted operation is visible on `cr_o` right after the rising edge that accepts it, and it is computed from the register value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| ba_i | input | 5 | First source bit index |
| bb_i | input | 5 | Second source bit index |
| bt_i | input | 5 | Target bit index |
| bf_i | input | 3 | Target field index |
| bfa_i | input | 3 | Source field index |
| fxm_i | input | 8 | Nibble enable mask for masked move |
| src_i | input | 32 | Source operand for masked move |
| xer_hi_i | input | 4 | Top nibble of exception register |
| cmp_i | input | 3 | Compare outcome: less, greater, equal |
| so_i | input | 1 | Summary overflow bit for compare write |
| cr_o | output | 32 | Condition register read port |

## Verification
The assertions take for granted that reset is held for at least one clock edge before operations start. They also assume every operand input is a known value whenever `valid_i` is high; index ranges need no assumption because every index width exactly covers the register. The stimulus asserts reset for several cycles first. It then drives each input from `$urandom` with a fixed seed, so no unknown value reaches an accepted operation. The random operation codes span all sixteen values, which covers the unused codes as well. Directed cases add overlapping bit indices, a field copied onto itself, and the empty and full nibble masks.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;
    localparam int CRU_DEF_W   = 32;
    localparam int CRU_DEF_FLD = 4;

    typedef enum logic [3:0] {
        CRU_NOP   = 4'd0,
        CRU_AND   = 4'd1,
        CRU_OR    = 4'd2,
        CRU_NAND  = 4'd3,
        CRU_XOR   = 4'd4,
        CRU_NOR   = 4'd5,
        CRU_EQV   = 4'd6,
        CRU_ANDC  = 4'd7,
        CRU_ORC   = 4'd8,
        CRU_FCOPY = 4'd9,
        CRU_MMOVE = 4'd10,
        CRU_XCOPY = 4'd11,
        CRU_CMPW  = 4'd12
    } cru_op_e;

    function automatic logic cru_is_bitop(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd8);
    endfunction
endpackage

// File: rtl/cr_bit_logic.sv
module cr_bit_logic
    import cr_unit_pkg::*;
#(
    parameter int CR_W   = 32,
    parameter int BIDX_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]   cr_i,
    input  logic [3:0]        op_i,
    input  logic [BIDX_W-1:0] ba_i,
    input  logic [BIDX_W-1:0] bb_i,
    input  logic [BIDX_W-1:0] bt_i,
    output logic [CR_W-1:0]   cr_o
);
    logic a_bit;
    logic b_bit;
    logic r_bit;

    always_comb begin
        a_bit = cr_i[CR_W-1-int'(ba_i)];
        b_bit = cr_i[CR_W-1-int'(bb_i)];
        unique case (cru_op_e'(op_i))
            CRU_AND:  r_bit = a_bit & b_bit;
            CRU_OR:   r_bit = a_bit | b_bit;
            CRU_NAND: r_bit = ~(a_bit & b_bit);
            CRU_XOR:  r_bit = a_bit ^ b_bit;
            CRU_NOR:  r_bit = ~(a_bit | b_bit);
            CRU_EQV:  r_bit = ~(a_bit ^ b_bit);
            CRU_ANDC: r_bit = a_bit & ~b_bit;
            CRU_ORC:  r_bit = a_bit | ~b_bit;
            default:  r_bit = cr_i[CR_W-1-int'(bt_i)];
        endcase
        cr_o = cr_i;
        cr_o[CR_W-1-int'(bt_i)] = r_bit;
    end
endmodule

// File: rtl/cr_field_ins.sv
module cr_field_ins #(
    parameter int CR_W   = 32,
    parameter int FLD_W  = 4,
    parameter int FIDX_W = $clog2(CR_W/FLD_W)
) (
    input  logic [CR_W-1:0]   cr_i,
    input  logic [FIDX_W-1:0] dst_i,
    input  logic [FLD_W-1:0]  nib_i,
    output logic [CR_W-1:0]   cr_o
);
    always_comb begin
        cr_o = cr_i;
        cr_o[CR_W-1-FLD_W*int'(dst_i) -: FLD_W] = nib_i;
    end
endmodule

// File: rtl/cr_mask_move.sv
module cr_mask_move #(
    parameter int CR_W  = 32,
    parameter int FLD_W = 4,
    parameter int NFLD  = CR_W/FLD_W
) (
    input  logic [CR_W-1:0] cr_i,
    input  logic [CR_W-1:0] src_i,
    input  logic [NFLD-1:0] mask_i,
    output logic [CR_W-1:0] cr_o
);
    for (genvar g = 0; g < NFLD; g++) begin : g_nib
        assign cr_o[g*FLD_W +: FLD_W] = mask_i[g] ? src_i[g*FLD_W +: FLD_W]
                                                  : cr_i[g*FLD_W +: FLD_W];
    end
endmodule

// File: rtl/cr_unit.sv
module cr_unit
    import cr_unit_pkg::*;
#(
    parameter int CR_W   = CRU_DEF_W,
    parameter int FLD_W  = CRU_DEF_FLD,
    parameter int NFLD   = CR_W/FLD_W,
    parameter int BIDX_W = $clog2(CR_W),
    parameter int FIDX_W = $clog2(NFLD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [BIDX_W-1:0] ba_i,
    input  logic [BIDX_W-1:0] bb_i,
    input  logic [BIDX_W-1:0] bt_i,
    input  logic [FIDX_W-1:0] bf_i,
    input  logic [FIDX_W-1:0] bfa_i,
    input  logic [NFLD-1:0]   fxm_i,
    input  logic [CR_W-1:0]   src_i,
    input  logic [FLD_W-1:0]  xer_hi_i,
    input  logic [FLD_W-2:0]  cmp_i,
    input  logic              so_i,
    output logic [CR_W-1:0]   cr_o
);
    logic [CR_W-1:0]  cr_q;
    logic [CR_W-1:0]  cr_nxt;
    logic [CR_W-1:0]  bit_res;
    logic [CR_W-1:0]  fld_res;
    logic [CR_W-1:0]  mov_res;
    logic [FLD_W-1:0] fld_data;

    cr_bit_logic #(.CR_W(CR_W), .BIDX_W(BIDX_W)) u_bit (
        .cr_i(cr_q), .op_i(op_i), .ba_i(ba_i), .bb_i(bb_i), .bt_i(bt_i),
        .cr_o(bit_res)
    );

    always_comb begin
        unique case (cru_op_e'(op_i))
            CRU_XCOPY: fld_data = xer_hi_i;
            CRU_CMPW:  fld_data = {cmp_i, so_i};
            default:   fld_data = cr_q[CR_W-1-FLD_W*int'(bfa_i) -: FLD_W];
        endcase
    end

    cr_field_ins #(.CR_W(CR_W), .FLD_W(FLD_W), .FIDX_W(FIDX_W)) u_fld (
        .cr_i(cr_q), .dst_i(bf_i), .nib_i(fld_data), .cr_o(fld_res)
    );

    cr_mask_move #(.CR_W(CR_W), .FLD_W(FLD_W), .NFLD(NFLD)) u_mov (
        .cr_i(cr_q), .src_i(src_i), .mask_i(fxm_i), .cr_o(mov_res)
    );

    always_comb begin
        cr_nxt = cr_q;
        if (valid_i) begin
            if (cru_is_bitop(op_i)) begin
                cr_nxt = bit_res;
            end else begin
                unique case (cru_op_e'(op_i))
                    CRU_FCOPY, CRU_XCOPY, CRU_CMPW: cr_nxt = fld_res;
                    CRU_MMOVE:                      cr_nxt = mov_res;
                    default:                        cr_nxt = cr_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cr_q <= '0;
        else     cr_q <= cr_nxt;
    end

    assign cr_o = cr_q;
endmodule

// File: rtl/cr_unit_chk.sv
module cr_unit_chk #(
    parameter int CR_W   = 32,
    parameter int FLD_W  = 4,
    parameter int NFLD   = CR_W/FLD_W,
    parameter int BIDX_W = $clog2(CR_W),
    parameter int FIDX_W = $clog2(NFLD)
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [BIDX_W-1:0] bt_i,
    input logic [FIDX_W-1:0] bf_i,
    input logic [FIDX_W-1:0] bfa_i,
    input logic [NFLD-1:0]   fxm_i,
    input logic [FLD_W-1:0]  xer_hi_i,
    input logic [FLD_W-2:0]  cmp_i,
    input logic              so_i,
    input logic [CR_W-1:0]   cr_o
);
    localparam logic [CR_W-1:0] ONE = {{(CR_W-1){1'b0}}, 1'b1};

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> cr_o == '0);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid_i || op_i == 4'd0 || op_i >= 4'd13) |=> $stable(cr_o));

    a_r3_single_bit: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i >= 4'd1 && op_i <= 4'd8) |=>
        (((cr_o ^ $past(cr_o)) & ~(ONE << (CR_W-1-int'($past(bt_i))))) == '0));

    a_r6_field_copy: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd9) |=>
        cr_o[CR_W-1-FLD_W*int'($past(bf_i)) -: FLD_W] ==
        $past(cr_o[CR_W-1-FLD_W*int'(bfa_i) -: FLD_W]));

    a_r7_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd10 && fxm_i == '0) |=> $stable(cr_o));

    a_r8_xer_copy: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd11) |=>
        cr_o[CR_W-1-FLD_W*int'($past(bf_i)) -: FLD_W] == $past(xer_hi_i));

    a_r9_cmp_order: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 4'd12) |=>
        cr_o[CR_W-1-FLD_W*int'($past(bf_i)) -: FLD_W] == $past({cmp_i, so_i}));
endmodule

bind cr_unit cr_unit_chk #(
    .CR_W(CR_W), .FLD_W(FLD_W), .NFLD(NFLD), .BIDX_W(BIDX_W), .FIDX_W(FIDX_W)
) u_cr_unit_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .bt_i(bt_i),
    .bf_i(bf_i), .bfa_i(bfa_i), .fxm_i(fxm_i), .xer_hi_i(xer_hi_i),
    .cmp_i(cmp_i), .so_i(so_i), .cr_o(cr_o)
);

// File: tb/test_cr_unit.sv
module test_cr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [4:0]  ba_i, bb_i, bt_i;
    logic [2:0]  bf_i, bfa_i;
    logic [7:0]  fxm_i;
    logic [31:0] src_i;
    logic [3:0]  xer_hi_i;
    logic [2:0]  cmp_i;
    logic        so_i;
    logic [31:0] cr_o;

    int unsigned errors = 0;
    int unsigned checks = 0;
    logic [31:0] model = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cr_unit i_cr_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .ba_i(ba_i), .bb_i(bb_i), .bt_i(bt_i), .bf_i(bf_i), .bfa_i(bfa_i),
        .fxm_i(fxm_i), .src_i(src_i), .xer_hi_i(xer_hi_i), .cmp_i(cmp_i),
        .so_i(so_i), .cr_o(cr_o)
    );

    function automatic string req_of(input logic v, input logic [3:0] op);
        if (!v || op == 4'd0 || op >= 4'd13) return "R2";
        if (op <= 4'd4)  return "R4/R3";
        if (op <= 4'd8)  return "R5/R3";
        if (op == 4'd9)  return "R6";
        if (op == 4'd10) return "R7";
        if (op == 4'd11) return "R8";
        return "R9";
    endfunction

    function automatic logic [31:0] ref_next(
        input logic [31:0] c, input logic v, input logic [3:0] op,
        input logic [4:0] ba, input logic [4:0] bb, input logic [4:0] bt,
        input logic [2:0] bf, input logic [2:0] bfa, input logic [7:0] fxm,
        input logic [31:0] src, input logic [3:0] xer, input logic [2:0] cmp,
        input logic so);
        logic [31:0] n;
        logic a, b, r;
        logic [3:0] nib;
        n = c;
        a = c[31-ba];
        b = c[31-bb];
        if (v) begin
            case (op)
                4'd1: r = a & b;
                4'd2: r = a | b;
                4'd3: r = !(a && b);
                4'd4: r = a ^ b;
                4'd5: r = !(a || b);
                4'd6: r = (a == b);
                4'd7: r = a & !b;
                4'd8: r = a | !b;
                default: r = 1'b0;
            endcase
            if (op >= 4'd1 && op <= 4'd8) n[31-bt] = r;
            if (op == 4'd9 || op == 4'd11 || op == 4'd12) begin
                if (op == 4'd9)       nib = c[31-4*bfa -: 4];
                else if (op == 4'd11) nib = xer;
                else                  nib = {cmp, so};
                for (int k = 0; k < 4; k++) n[31-4*bf-k] = nib[3-k];
            end
            if (op == 4'd10)
                for (int i = 0; i < 8; i++)
                    if (fxm[i]) n[4*i +: 4] = src[4*i +: 4];
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (cr_o !== exp) begin
            errors++;
            $display("FAIL %s: cr_o=%h expected=%h", req, cr_o, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [3:0] op,
        input logic [4:0] ba, input logic [4:0] bb, input logic [4:0] bt,
        input logic [2:0] bf, input logic [2:0] bfa, input logic [7:0] fxm,
        input logic [31:0] src, input logic [3:0] xer, input logic [2:0] cmp,
        input logic so);
        logic [31:0] exp;
        @(negedge clk);
        valid_i = v; op_i = op; ba_i = ba; bb_i = bb; bt_i = bt;
        bf_i = bf; bfa_i = bfa; fxm_i = fxm; src_i = src;
        xer_hi_i = xer; cmp_i = cmp; so_i = so;
        exp = ref_next(model, v, op, ba, bb, bt, bf, bfa, fxm, src, xer, cmp, so);
        @(posedge clk);
        #1;
        check({req_of(v, op), "/R10"}, exp);
        model = exp;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cr_o=%h expected=completion", cr_o);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; valid_i = 0; op_i = 0; ba_i = 0; bb_i = 0; bt_i = 0;
        bf_i = 0; bfa_i = 0; fxm_i = 0; src_i = 0; xer_hi_i = 0; cmp_i = 0; so_i = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R1", 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R7: full mask loads all, empty mask keeps all
        apply(1, 4'd10, 0, 0, 0, 0, 0, 8'hFF, 32'hA5C3_1E7B, 0, 0, 0);
        apply(1, 4'd10, 0, 0, 0, 0, 0, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
        apply(1, 4'd10, 0, 0, 0, 0, 0, 8'h81, 32'h0000_0000, 0, 0, 0);
        // R3: bit 0 is physical 31; overlapping indices
        apply(1, 4'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 4'd8, 3, 3, 3, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 4'd7, 31, 31, 31, 0, 0, 0, 0, 0, 0, 0);
        // R6: copy onto itself and distinct fields
        apply(1, 4'd9, 0, 0, 0, 5, 5, 0, 0, 0, 0, 0);
        apply(1, 4'd9, 0, 0, 0, 7, 0, 0, 0, 0, 0, 0);
        // R8, R9 order checks
        apply(1, 4'd11, 0, 0, 0, 2, 0, 0, 0, 4'b1000, 0, 0);
        apply(1, 4'd12, 0, 0, 0, 3, 0, 0, 0, 0, 3'b100, 1'b0);
        apply(1, 4'd12, 0, 0, 0, 6, 0, 0, 0, 0, 3'b001, 1'b1);
        // R2: unused code and idle strobe
        apply(1, 4'd14, 1, 2, 3, 1, 2, 8'hFF, 32'h1234_5678, 4'hF, 3'h7, 1);
        apply(0, 4'd10, 1, 2, 3, 1, 2, 8'hFF, 32'h1234_5678, 4'hF, 3'h7, 1);

        for (int n = 0; n < 600; n++) begin
            apply($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)),
                  5'($urandom), 5'($urandom), 5'($urandom), 3'($urandom),
                  3'($urandom), 8'($urandom), $urandom, 4'($urandom),
                  3'($urandom), 1'($urandom));
        end

        // R1: reset mid-run clears
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 32'h0);
        model = '0;
        @(negedge clk);
        rst = 1'b0;
        apply(1, 4'd6, 4, 9, 4, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule